// File: doc/BRIEF.md
# Descriptor-Driven Scatter-Gather DMA Engine

This block is the bus-master half of a storage device's DMA path. The device command logic first arms it with a transfer direction and the total byte count of the command. A later start request supplies the memory address of a table of region descriptors. The engine then reads the descriptors one at a time. It waits a media delay that depends on the region size. It then moves each region between the device's local sector buffer and system memory. Every memory transaction it issues stays inside a single memory page.

The memory port uses a request, grant and done handshake. A descriptor fetch is an 8-byte read whose data comes back on the done cycle. A data transaction carries an address, a length and the matching byte offset into the local buffer. When the memory side reports that it is busy, the engine backs off for a fixed number of cycles and then repeats the same step. The engine reports the end of the descriptor table as either a clean finish or a command error, and an abort from the command logic stops the engine at any point. Separate byte, transaction and full-page counters are kept for each direction.

Top module: `sgd_engine`

## Requirements
- R1: After reset the engine is idle, with `mem_req_o`, `done_o`, `cmd_err_o` and `start_err_o` low and all six counters at zero.
- R2: The first descriptor fetch after a start reads 8 bytes (`mem_we_o`=0) at the table address with bits 1:0 forced to zero.
- R3: Each later descriptor fetch reads 8 bytes at the previous fetch address plus 8.
- R4: A descriptor's region (base in `mem_rdata_i[31:0]`, byte count in `mem_rdata_i[47:32]`) is issued as consecutive transactions. Each one is as long as possible without crossing a 4096-byte page boundary. While ungranted and not busy, a request holds its address.
- R5: When `mem_busy_i` is high in a cycle where `mem_req_o` is high, the request drops at the next edge. The same request comes back exactly BACKOFF_CYC+2 cycles after that busy cycle, and it is not counted.
- R6: With `dir_i`=0 (device to memory), data transactions have `mem_we_o`=1. With `dir_i`=1 (memory to device) they have `mem_we_o`=0. `mem_boff_o` gives the byte offset of the transaction within its region.
- R7: After the done of a fetch whose count is nonzero, the first data request of that region appears BASE_DELAY + count/512 + 2 cycles later.
- R8: After the last transaction of a region, the engine fetches the next descriptor if `mem_rdata_i[63]` (end-of-table) was clear. If it was set and the remaining command byte count is zero, the engine pulses `done_o` once and goes idle.
- R9: If the end-of-table region finishes with a nonzero remaining command byte count, the engine pulses `cmd_err_o` instead of `done_o` and goes idle.
- R10: Each granted data transaction adds its length to the byte counter of its direction and one to the transaction counter of that direction. It also adds one to the full-page counter of that direction when the length is 4096.
- R11: `abort_i` while the engine is armed or busy pulses `cmd_err_o` once and returns the engine to idle, so that no further request is made. `abort_i` while idle has no effect.
- R12: `go_i` while the engine is not armed is ignored and pulses `start_err_o` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm for a DMA command (taken only when idle) |
| dir_i | input | 1 | 0: device to memory, 1: memory to device |
| cmd_bytes_i | input | BYTES_W | Total bytes of the command |
| go_i | input | 1 | Start request from the host |
| tbl_base_i | input | ADDR_W | Descriptor table address (bits 1:0 ignored) |
| abort_i | input | 1 | Abort request |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1: write to memory |
| mem_addr_o | output | ADDR_W | Transaction address |
| mem_len_o | output | LEN_W | Transaction length in bytes |
| mem_boff_o | output | LEN_W | Local buffer offset of the transaction |
| mem_busy_i | input | 1 | Memory side busy, back off |
| mem_gnt_i | input | 1 | Request accepted |
| mem_done_i | input | 1 | Transaction finished |
| mem_rdata_i | input | 64 | Descriptor data, valid with done |
| done_o | output | 1 | Table finished cleanly (pulse) |
| cmd_err_o | output | 1 | Command error or abort (pulse) |
| start_err_o | output | 1 | Start request rejected (pulse) |
| tomem_bytes_o | output | CNT_W | Bytes moved to memory |
| tomem_txn_o | output | CNT_W | Transactions to memory |
| tomem_full_o | output | CNT_W | Full-page transactions to memory |
| todev_bytes_o | output | CNT_W | Bytes moved to the device |
| todev_txn_o | output | CNT_W | Transactions to the device |
| todev_full_o | output | CNT_W | Full-page transactions to the device |

## Verification
The bench plays the memory side on falling edges. It grants a request at the first falling edge where the request is seen and returns done three falling edges later. It compares each granted request with the head of a queue that a driver task fills from the descriptor list. A fetch's done is followed by its first data request BASE_DELAY + sectors + 2 falling edges later, and a busy cycle is followed by the retried request BACKOFF_CYC + 2 falling edges later. The bench counts those edges from the event and compares the count with the expected value. The single-cycle pulses `done_o`, `cmd_err_o` and `start_err_o` appear on the falling edge after the edge that produces them, so the bench samples them there.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARMED, ST_FREQ, ST_FWAIT, ST_DELAY,
    ST_XREQ, ST_XWAIT, ST_BACKOFF, ST_REND
  } sgd_state_e;

  // 64-bit descriptor as returned by a fetch
  typedef struct packed {
    logic        last;
    logic [14:0] spare;
    logic [15:0] nbytes;
    logic [31:0] base;
  } sgd_desc_t;

  // Longest piece starting at addr that neither overruns rem nor a page
  function automatic logic [31:0] sgd_chunk(input logic [31:0] addr,
                                            input logic [31:0] rem,
                                            input logic [31:0] page_bytes);
    logic [31:0] room;
    room = page_bytes - (addr & (page_bytes - 32'd1));
    return (rem < room) ? rem : room;
  endfunction

  // Media wait before a region: fixed part plus one cycle per sector
  function automatic logic [31:0] sgd_wait(input logic [31:0] fixed_cyc,
                                           input logic [31:0] nbytes,
                                           input int unsigned sect_sh);
    return fixed_cyc + (nbytes >> sect_sh);
  endfunction

endpackage

// File: rtl/sgd_chunker.sv
module sgd_chunker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  rem_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              full_o
);
  import sgd_pkg::*;

  logic [31:0] piece;

  always_comb begin
    piece  = sgd_chunk(32'(addr_i), 32'(rem_i), 32'(PAGE_BYTES));
    len_o  = LEN_W'(piece);
    full_o = (piece == 32'(PAGE_BYTES));
  end
endmodule

// File: rtl/sgd_timer.sv
module sgd_timer #(
  parameter int TMR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] val_i,
  output logic             zero_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sgd_stats.sv
module sgd_stats #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire_i,
  input  logic                  dir_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic                  full_i,
  output logic [1:0][CNT_W-1:0] bytes_o,
  output logic [1:0][CNT_W-1:0] txn_o,
  output logic [1:0][CNT_W-1:0] full_o
);
  for (genvar g = 0; g < 2; g++) begin : g_dir
    logic hit;
    assign hit = fire_i && (dir_i == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_o[g] <= '0;
        txn_o[g]   <= '0;
        full_o[g]  <= '0;
      end else if (hit) begin
        bytes_o[g] <= bytes_o[g] + CNT_W'(len_i);
        txn_o[g]   <= txn_o[g] + 1'b1;
        if (full_i) full_o[g] <= full_o[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sgd_engine.sv
module sgd_engine #(
  parameter int ADDR_W       = 32,
  parameter int BYTES_W      = 20,
  parameter int LEN_W        = 16,
  parameter int CNT_W        = 32,
  parameter int PAGE_BYTES   = 4096,
  parameter int SECTOR_BYTES = 512,
  parameter int BASE_DELAY   = 3,
  parameter int BACKOFF_CYC  = 4,
  parameter int TMR_W        = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              dir_i,
  input  logic [BYTES_W-1:0] cmd_bytes_i,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              abort_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LEN_W-1:0]  mem_len_o,
  output logic [LEN_W-1:0]  mem_boff_o,
  input  logic              mem_busy_i,
  input  logic              mem_gnt_i,
  input  logic              mem_done_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              done_o,
  output logic              cmd_err_o,
  output logic              start_err_o,
  output logic [CNT_W-1:0]  tomem_bytes_o,
  output logic [CNT_W-1:0]  tomem_txn_o,
  output logic [CNT_W-1:0]  tomem_full_o,
  output logic [CNT_W-1:0]  todev_bytes_o,
  output logic [CNT_W-1:0]  todev_txn_o,
  output logic [CNT_W-1:0]  todev_full_o
);
  import sgd_pkg::*;

  localparam int          SECT_SH    = $clog2(SECTOR_BYTES);
  localparam int          DESC_BYTES = 8;
  localparam logic [LEN_W-1:0] DESC_LEN = LEN_W'(DESC_BYTES);

  sgd_state_e         state_q;
  logic               dir_q;
  logic [BYTES_W-1:0] cmd_rem_q;
  logic [ADDR_W-1:0]  tbl_ptr_q;
  logic [ADDR_W-1:0]  cur_addr_q;
  logic [LEN_W-1:0]   reg_rem_q;
  logic [LEN_W-1:0]   boff_q;
  logic               last_q;
  logic               retry_fetch_q;

  // Named internal events
  logic       in_fetch, in_data, issuing;
  logic       abort_take, bus_reject, fetch_grant, data_grant;
  logic       fetch_done, data_done, go_bad;
  logic       tmr_zero, tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic [LEN_W-1:0] piece_len;
  logic       piece_full;
  sgd_desc_t  desc;

  assign desc        = sgd_desc_t'(mem_rdata_i);
  assign in_fetch    = (state_q == ST_FREQ);
  assign in_data     = (state_q == ST_XREQ);
  assign issuing     = in_fetch || in_data;
  assign abort_take  = abort_i && (state_q != ST_IDLE);
  assign bus_reject  = issuing && mem_busy_i && !abort_i;
  assign fetch_grant = in_fetch && !mem_busy_i && mem_gnt_i && !abort_i;
  assign data_grant  = in_data && !mem_busy_i && mem_gnt_i && !abort_i;
  assign fetch_done  = (state_q == ST_FWAIT) && mem_done_i && !abort_i;
  assign data_done   = (state_q == ST_XWAIT) && mem_done_i && !abort_i;
  assign go_bad      = go_i && (state_q != ST_ARMED);

  sgd_chunker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .addr_i (cur_addr_q),
    .rem_i  (reg_rem_q),
    .len_o  (piece_len),
    .full_o (piece_full)
  );

  assign tmr_load = bus_reject || fetch_done;
  assign tmr_val  = bus_reject ? TMR_W'(BACKOFF_CYC)
                               : TMR_W'(sgd_wait(32'(BASE_DELAY), 32'(desc.nbytes), SECT_SH));

  sgd_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  logic [1:0][CNT_W-1:0] st_bytes, st_txn, st_full;

  sgd_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_stats (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (data_grant),
    .dir_i   (dir_q),
    .len_i   (piece_len),
    .full_i  (piece_full),
    .bytes_o (st_bytes),
    .txn_o   (st_txn),
    .full_o  (st_full)
  );

  assign tomem_bytes_o = st_bytes[0];
  assign tomem_txn_o   = st_txn[0];
  assign tomem_full_o  = st_full[0];
  assign todev_bytes_o = st_bytes[1];
  assign todev_txn_o   = st_txn[1];
  assign todev_full_o  = st_full[1];

  // Memory request outputs
  assign mem_req_o  = issuing;
  assign mem_we_o   = in_data && !dir_q;
  assign mem_addr_o = in_fetch ? tbl_ptr_q : cur_addr_q;
  assign mem_len_o  = in_fetch ? DESC_LEN : piece_len;
  assign mem_boff_o = in_fetch ? '0 : boff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      dir_q         <= 1'b0;
      cmd_rem_q     <= '0;
      tbl_ptr_q     <= '0;
      cur_addr_q    <= '0;
      reg_rem_q     <= '0;
      boff_q        <= '0;
      last_q        <= 1'b0;
      retry_fetch_q <= 1'b0;
      done_o        <= 1'b0;
      cmd_err_o     <= 1'b0;
      start_err_o   <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      cmd_err_o   <= 1'b0;
      start_err_o <= go_bad;
      if (abort_take) begin
        state_q   <= ST_IDLE;
        cmd_err_o <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (arm_i) begin
            dir_q     <= dir_i;
            cmd_rem_q <= cmd_bytes_i;
            state_q   <= ST_ARMED;
          end
          ST_ARMED: if (go_i) begin
            tbl_ptr_q <= {tbl_base_i[ADDR_W-1:2], 2'b00};
            state_q   <= ST_FREQ;
          end
          ST_FREQ: begin
            if (bus_reject) begin
              retry_fetch_q <= 1'b1;
              state_q       <= ST_BACKOFF;
            end else if (fetch_grant) begin
              state_q <= ST_FWAIT;
            end
          end
          ST_FWAIT: if (fetch_done) begin
            last_q     <= desc.last;
            cur_addr_q <= ADDR_W'(desc.base);
            reg_rem_q  <= LEN_W'(desc.nbytes);
            boff_q     <= '0;
            tbl_ptr_q  <= tbl_ptr_q + ADDR_W'(DESC_BYTES);
            state_q    <= ST_DELAY;
          end
          ST_DELAY: if (tmr_zero) begin
            state_q <= (reg_rem_q != '0) ? ST_XREQ : ST_REND;
          end
          ST_XREQ: begin
            if (bus_reject) begin
              retry_fetch_q <= 1'b0;
              state_q       <= ST_BACKOFF;
            end else if (data_grant) begin
              state_q <= ST_XWAIT;
            end
          end
          ST_XWAIT: if (data_done) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(piece_len);
            reg_rem_q  <= reg_rem_q - piece_len;
            boff_q     <= boff_q + piece_len;
            cmd_rem_q  <= cmd_rem_q - BYTES_W'(piece_len);
            state_q    <= (reg_rem_q == piece_len) ? ST_REND : ST_XREQ;
          end
          ST_BACKOFF: if (tmr_zero) begin
            state_q <= retry_fetch_q ? ST_FREQ : ST_XREQ;
          end
          ST_REND: begin
            if (last_q) begin
              state_q <= ST_IDLE;
              if (cmd_rem_q == '0) done_o    <= 1'b1;
              else                 cmd_err_o <= 1'b1;
            end else begin
              state_q <= ST_FREQ;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sgd_engine_chk.sv
module sgd_engine_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_busy_i,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LEN_W-1:0]  mem_len_o,
  input logic              in_fetch,
  input logic              abort_i,
  input logic              go_i,
  input logic              done_o,
  input logic              cmd_err_o,
  input logic              start_err_o
);
  logic [31:0] page_off;
  assign page_off = 32'(mem_addr_o) & 32'(PAGE_BYTES - 1);

  AST_FETCH_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && in_fetch |-> (mem_addr_o[1:0] == 2'b00) && (mem_len_o == LEN_W'(8))); // R2

  AST_PIECE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !in_fetch |-> (mem_len_o != '0) && (page_off + 32'(mem_len_o) <= 32'(PAGE_BYTES))); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_busy_i && !mem_gnt_i && !abort_i |=> mem_req_o && $stable(mem_addr_o)); // R4

  AST_BUSY_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_busy_i |=> !mem_req_o); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o); // R8

  AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && cmd_err_o)); // R9

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i && mem_req_o |=> !mem_req_o && cmd_err_o); // R11

  AST_START_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_err_o |-> $past(go_i)); // R12
endmodule

bind sgd_engine sgd_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_busy_i  (mem_busy_i),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_o  (mem_addr_o),
  .mem_len_o   (mem_len_o),
  .in_fetch    (in_fetch),
  .abort_i     (abort_i),
  .go_i        (go_i),
  .done_o      (done_o),
  .cmd_err_o   (cmd_err_o),
  .start_err_o (start_err_o)
);

// File: tb/sgd_engine_bench.sv
module sgd_engine_bench;
  localparam int PAGE  = 4096;
  localparam int BASE  = 3;
  localparam int BOFF  = 4;
  localparam int SECT  = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 1'b0, dir_i = 1'b0, go_i = 1'b0, abort_i = 1'b0;
  logic [19:0] cmd_bytes_i = '0;
  logic [31:0] tbl_base_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [15:0] mem_len_o, mem_boff_o;
  logic        mem_busy_i = 1'b0, mem_gnt_i = 1'b0, mem_done_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        done_o, cmd_err_o, start_err_o;
  logic [31:0] tomem_bytes_o, tomem_txn_o, tomem_full_o;
  logic [31:0] todev_bytes_o, todev_txn_o, todev_full_o;

  always #2 clk = ~clk;

  sgd_engine u_sgd_engine (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .dir_i(dir_i), .cmd_bytes_i(cmd_bytes_i),
    .go_i(go_i), .tbl_base_i(tbl_base_i), .abort_i(abort_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_len_o(mem_len_o), .mem_boff_o(mem_boff_o), .mem_busy_i(mem_busy_i),
    .mem_gnt_i(mem_gnt_i), .mem_done_i(mem_done_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .cmd_err_o(cmd_err_o), .start_err_o(start_err_o),
    .tomem_bytes_o(tomem_bytes_o), .tomem_txn_o(tomem_txn_o), .tomem_full_o(tomem_full_o),
    .todev_bytes_o(todev_bytes_o), .todev_txn_o(todev_txn_o), .todev_full_o(todev_full_o)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [15:0] len;
    logic [15:0] boff;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [63:0] dmem[16];
  logic [31:0] tbl_al;
  int n_chk = 0, n_bad = 0;
  bit summary_done = 0;
  longint exp_b[2], exp_t[2], exp_f[2];

  // memory model state
  int wait_cnt = 0, busy_at = -1, req_idx = 0;
  bit gap_armed = 0, low_armed = 0;
  int gap_cnt = 0, gap_exp = 0, low_cnt = 0;
  bit pend_fetch = 0;
  logic [63:0] pend_data = '0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // memory side + scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      mem_gnt_i = 0; mem_done_i = 0; mem_busy_i = 0;
      gap_cnt++; low_cnt++;
      if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) begin
          mem_done_i  = 1;
          mem_rdata_i = pend_data;
          if (pend_fetch && pend_data[47:32] != 0) begin
            gap_armed = 1; gap_cnt = 0;
            gap_exp = BASE + int'(pend_data[47:32]) / SECT + 2;
          end
        end
      end else if (mem_req_o) begin
        if (gap_armed) begin
          check(gap_cnt == gap_exp, "R7 region wait", gap_cnt, gap_exp);
          gap_armed = 0;
        end
        if (low_armed) begin
          check(low_cnt == BOFF + 2, "R5 backoff length", low_cnt, BOFF + 2);
          low_armed = 0;
        end
        if (req_idx == busy_at) begin
          mem_busy_i = 1; busy_at = -1; low_armed = 1; low_cnt = 0;
        end else begin
          mem_gnt_i = 1;
          req_idx++;
          if (exp_q.size() == 0) begin
            check(0, "R8 unexpected request", mem_addr_o, 0);
          end else begin
            item_t e;
            e = exp_q.pop_front();
            check(mem_addr_o == e.addr, e.tag, mem_addr_o, e.addr);
            check(mem_len_o == e.len, "R4 length", mem_len_o, e.len);
            check(mem_we_o == e.we, "R6 direction", mem_we_o, e.we);
            check(mem_boff_o == e.boff, "R6 buffer offset", mem_boff_o, e.boff);
          end
          pend_fetch = (mem_len_o == 16'd8);
          pend_data  = pend_fetch ? dmem[(mem_addr_o - tbl_al) >> 3] : 64'd0;
          wait_cnt = 3;
        end
      end
    end
  end

  // driver: builds expected traffic from the descriptor list
  task automatic build(input logic dir, input int ndesc);
    int a, rem, off, l;
    for (int i = 0; i < ndesc; i++) begin
      item_t f;
      f.we = 0; f.addr = tbl_al + 32'(8 * i); f.len = 8; f.boff = 0;
      f.tag = (i == 0) ? "R2 first fetch address" : "R3 next fetch address";
      exp_q.push_back(f);
      a = int'(dmem[i][31:0]); rem = int'(dmem[i][47:32]); off = 0;
      while (rem > 0) begin
        item_t d;
        l = PAGE - (a % PAGE);
        if (rem < l) l = rem;
        d.we = !dir; d.addr = 32'(a); d.len = 16'(l); d.boff = 16'(off);
        d.tag = "R4 piece address";
        exp_q.push_back(d);
        exp_b[dir] += l; exp_t[dir] += 1;
        if (l == PAGE) exp_f[dir] += 1;
        a += l; rem -= l; off += l;
      end
      if (dmem[i][63]) break;
    end
  endtask

  task automatic pulse_arm(input logic dir, input int bytes);
    @(negedge clk); arm_i = 1; dir_i = dir; cmd_bytes_i = 20'(bytes);
    @(negedge clk); arm_i = 0;
  endtask

  task automatic pulse_go(input logic [31:0] base);
    @(negedge clk); go_i = 1; tbl_base_i = base;
    @(negedge clk); go_i = 0;
  endtask

  task automatic run_cmd(input logic dir, input int bytes, input logic [31:0] base,
                         input int ndesc, input bit want_done);
    bit got_done, got_err;
    tbl_al = {base[31:2], 2'b00};
    req_idx = 0;
    build(dir, ndesc);
    pulse_arm(dir, bytes);
    pulse_go(base);
    got_done = 0; got_err = 0;
    for (int c = 0; c < 3000 && !got_done && !got_err; c++) begin
      @(negedge clk);
      got_done = done_o; got_err = cmd_err_o;
    end
    if (want_done) check(got_done && !got_err, "R8 clean finish", {got_done, got_err}, 2'b10);
    else           check(got_err && !got_done, "R9 leftover bytes error", {got_done, got_err}, 2'b01);
    check(exp_q.size() == 0, "R8 all traffic issued", exp_q.size(), 0);
    exp_q.delete();
    check(tomem_bytes_o == exp_b[0], "R10 to-mem bytes", tomem_bytes_o, exp_b[0]);
    check(tomem_txn_o == exp_t[0], "R10 to-mem txns", tomem_txn_o, exp_t[0]);
    check(tomem_full_o == exp_f[0], "R10 to-mem full", tomem_full_o, exp_f[0]);
    check(todev_bytes_o == exp_b[1], "R10 to-dev bytes", todev_bytes_o, exp_b[1]);
    check(todev_txn_o == exp_t[1], "R10 to-dev txns", todev_txn_o, exp_t[1]);
    check(todev_full_o == exp_f[1], "R10 to-dev full", todev_full_o, exp_f[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    bit seen;
    for (int i = 0; i < 2; i++) begin exp_b[i] = 0; exp_t[i] = 0; exp_f[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!mem_req_o && !done_o && !cmd_err_o && !start_err_o, "R1 reset outputs",
          {mem_req_o, done_o, cmd_err_o, start_err_o}, 0);
    check(tomem_bytes_o == 0 && todev_txn_o == 0 && todev_full_o == 0, "R1 reset counters",
          tomem_bytes_o, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Test 1: one region to memory, busy on the fetch (R2 R5 R6 R7 R8)
    dmem[0] = {1'b1, 15'd0, 16'd1024, 32'h0000_2000};
    busy_at = 0;
    run_cmd(1'b0, 1024, 32'h0000_1003, 1, 1'b1);

    // Test 2: two regions to device, page crossing, busy on a data piece (R3 R4 R5 R10)
    dmem[0] = {1'b0, 15'd0, 16'd1024, 32'h0000_3E00};
    dmem[1] = {1'b1, 15'd0, 16'd8192, 32'h0001_0000};
    busy_at = 2;
    run_cmd(1'b1, 9216, 32'h0000_5000, 2, 1'b1);

    // Test 3: end-of-table with bytes left over (R9)
    dmem[0] = {1'b1, 15'd0, 16'd512, 32'h0000_7100};
    run_cmd(1'b0, 2048, 32'h0000_6000, 1, 1'b0);

    // Test 4: abort while waiting for a fetch (R11)
    tbl_al = 32'h0000_8000;
    dmem[0] = {1'b1, 15'd0, 16'd512, 32'h0000_9000};
    begin item_t f; f.we = 0; f.addr = tbl_al; f.len = 8; f.boff = 0; f.tag = "R2 first fetch address";
      exp_q.push_back(f); end
    req_idx = 0;
    pulse_arm(1'b0, 512);
    pulse_go(32'h0000_8000);
    while (!mem_gnt_i) @(negedge clk);
    abort_i = 1;
    @(negedge clk); abort_i = 0;
    check(cmd_err_o == 1, "R11 abort reports error", cmd_err_o, 1);
    seen = 0;
    repeat (30) begin @(negedge clk); if (mem_req_o || done_o) seen = 1; end
    check(!seen, "R11 no activity after abort", seen, 0);
    check(tomem_txn_o == exp_t[0], "R11 counters untouched", tomem_txn_o, exp_t[0]);

    // abort while idle is ignored (R11)
    @(negedge clk); abort_i = 1;
    @(negedge clk); abort_i = 0;
    seen = cmd_err_o;
    repeat (3) begin @(negedge clk); if (cmd_err_o) seen = 1; end
    check(!seen, "R11 idle abort ignored", seen, 0);

    // go while idle: rejected (R12)
    @(negedge clk); go_i = 1; tbl_base_i = 32'h0000_A000;
    @(negedge clk); go_i = 0;
    check(start_err_o == 1, "R12 start error pulse", start_err_o, 1);
    seen = 0;
    repeat (20) begin @(negedge clk); if (mem_req_o) seen = 1; end
    check(!seen && !start_err_o, "R12 start ignored", seen, 0);

    summary();
    $finish;
  end
endmodule